// File: doc/BRIEF.md
# Three-Phase PWM Generator

This block drives the six gate signals of a three-phase inverter bridge. Each phase has a high-side and a low-side output. A single 16-bit counter counts up and then down, so every pulse is centred. Each phase compares its duty value against the counter, and the result is turned into a pair of complementary gate signals with a programmed dead band between them.

Software writes the period, the three duty values, the dead time, the minimum pulse width and a control word through a simple write port. Period and duty writes land in shadow registers. They reach the comparators only at the period boundary, or also at the period midpoint when double update is selected. Edges are placed to one clock cycle. A sync output marks each period start for an ADC trigger. On top of the switching pattern the block can gate a chopping square wave onto either output group, flip the output polarity, and mask any single output. A trip input drives everything inactive at once. The trip is latched, and the outputs stay off until software re-arms the block.

Top module: `pwm3_gen`

## Requirements
- R1: The counter starts at 0 after reset and counts 0,1,..,P,P-1,..,1,0,1,.., where P is the active period. A period value of 0 is treated as 1. A written period becomes active on the clock edge at which the counter is 0.
- R2: `sync` is high exactly in the cycles in which the counter is 0, which is once per 2*P cycles.
- R3: A phase's raw high-side request is (counter < effective duty). It appears at the phase outputs one cycle later, through a register.
- R4: Let d be the duty, P the period and w the minimum width. If d < w, the effective duty is 0 (always off). Otherwise, if d >= P or P-d < w, the effective duty is P+1 (always on). Otherwise it is d.
- R5: Duty writes (addresses 1, 2 and 3 for phases A, B and C) reach the comparators at the edge where the counter is 0. When control bit 6 is set, they also reach the comparators at the edge where the counter equals P. At all other times the active duties hold.
- R6: When a phase's raw request changes, both of its outputs are inactive for D cycles, where D is the dead time written at address 4. After that the side that was turned on goes active.
- R7: Control word (address 6) bits 5:0 enable the outputs individually. Bit 2i enables the high side of phase i and bit 2i+1 enables its low side (A=0, B=1, C=2). A disabled output is inactive.
- R8: A chopping square wave starts low at reset and toggles every CHOP_HALF cycles. Control bit 7 gates it onto the high-side outputs and control bit 8 gates it onto the low-side outputs.
- R9: With `pol_hi`=1 an active output is 1. With `pol_hi`=0 an active output is 0 and an inactive output is 1.
- R10: While `trip` is high, all six outputs are inactive in the same cycle. A latch set by `trip` keeps them inactive until a write to address 7 while `trip` is low. A write to address 7 while `trip` is high is ignored.
- R11: Reset clears the duties, the dead time, the minimum width, the control word and the trip latch, so all outputs are inactive and `sync` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 period, 1-3 duty A-C, 4 dead time, 5 min width, 6 control, 7 re-arm) |
| wr_data | input | 16 | Write data |
| trip | input | 1 | Shutdown request, acts without a clock |
| pol_hi | input | 1 | 1: active-high outputs, 0: active-low outputs |
| gate_hi | output | 3 | High-side gate outputs, phases A..C |
| gate_lo | output | 3 | Low-side gate outputs, phases A..C |
| sync | output | 1 | High in the counter-zero cycle of each period |

## Verification
The bench builds the block with PERIOD_RST=8 and CHOP_HALF=3. Short periods between 1 and 10 then put many period boundaries, midpoint reloads and chop toggles into a few hundred cycles. A 3-cycle chop wave is out of step with the switching period, so chop gating lands on both rising and falling pulse edges. Small duty, dead-time and minimum-width values reach the full-on and full-off saturation points. They also reach the case in which the dead band is wider than a pulse.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  localparam int DW = 16;
  typedef logic [DW-1:0] word_t;
  typedef logic [DW:0]   wide_t;

  typedef enum logic [2:0] {
    A_PERIOD = 3'd0,
    A_DUTY_A = 3'd1,
    A_DUTY_B = 3'd2,
    A_DUTY_C = 3'd3,
    A_DEAD   = 3'd4,
    A_MINW   = 3'd5,
    A_CTRL   = 3'd6,
    A_REARM  = 3'd7
  } addr_e;

  localparam int CTRL_W   = 9;
  localparam int B_DOUBLE = 6;
  localparam int B_CHOPHI = 7;
  localparam int B_CHOPLO = 8;

  // A period of zero would stall the up/down counter; the smallest legal value is one.
  function automatic word_t clamp_period(word_t p);
    return (p == '0) ? word_t'(1) : p;
  endfunction

  // Compare threshold after minimum-width saturation; P+1 means always on.
  function automatic wide_t eff_duty(word_t d, word_t p, word_t mw);
    wide_t full;
    full = {1'b0, p} + wide_t'(1);
    if (d < mw)        return '0;
    if (d >= p)        return full;
    if ((p - d) < mw)  return full;
    return {1'b0, d};
  endfunction
endpackage

// File: rtl/pwm3_counter.sv
module pwm3_counter
  import pwm3_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t period,
  output word_t cnt,
  output logic  start_ev,
  output logic  mid_ev
);
  logic up_q;

  assign start_ev = (cnt == '0);
  assign mid_ev   = (cnt == period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      up_q <= 1'b1;
    end else if (cnt == '0) begin
      up_q <= 1'b1;
      cnt  <= word_t'(1);
    end else if (up_q && (cnt >= period)) begin
      up_q <= 1'b0;
      cnt  <= cnt - word_t'(1);
    end else if (up_q) begin
      cnt  <= cnt + word_t'(1);
    end else begin
      cnt  <= cnt - word_t'(1);
    end
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= period);

  // R2
  sync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !start_ev);
endmodule

// File: rtl/pwm3_regs.sv
module pwm3_regs
  import pwm3_pkg::*;
#(
  parameter int PERIOD_RST = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  word_t             wr_data,
  input  logic              start_ev,
  input  logic              mid_ev,
  input  logic              trip,
  output word_t             period_act,
  output word_t [2:0]       duty_act,
  output word_t             dead,
  output word_t             minw,
  output logic [CTRL_W-1:0] ctrl,
  output logic              tripped
);
  word_t       period_sh;
  word_t [2:0] duty_sh;
  logic        dbl;
  logic        dbl_load;
  logic        rearm_req;

  assign dbl       = ctrl[B_DOUBLE];
  assign dbl_load  = mid_ev && dbl;
  assign rearm_req = wr_en && (addr_e'(wr_addr) == A_REARM);

  // Host side: shadows and immediate registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_sh <= word_t'(PERIOD_RST);
      duty_sh   <= '0;
      dead      <= '0;
      minw      <= '0;
      ctrl      <= '0;
    end else if (wr_en) begin
      case (addr_e'(wr_addr))
        A_PERIOD: period_sh  <= wr_data;
        A_DUTY_A: duty_sh[0] <= wr_data;
        A_DUTY_B: duty_sh[1] <= wr_data;
        A_DUTY_C: duty_sh[2] <= wr_data;
        A_DEAD:   dead       <= wr_data;
        A_MINW:   minw       <= wr_data;
        A_CTRL:   ctrl       <= wr_data[CTRL_W-1:0];
        default:  ;
      endcase
    end
  end

  // Active copies move only at update points
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_act <= clamp_period(word_t'(PERIOD_RST));
      duty_act   <= '0;
    end else if (start_ev) begin
      period_act <= clamp_period(period_sh);
      duty_act   <= duty_sh;
    end else if (dbl_load) begin
      duty_act   <= duty_sh;
    end
  end

  // Shutdown latch, trip has priority over re-arm
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tripped <= 1'b0;
    else if (trip)      tripped <= 1'b1;
    else if (rearm_req) tripped <= 1'b0;
  end

  // R5
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_ev || dbl_load) |=> $stable(duty_act));

  // R1
  period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_ev |=> $stable(period_act));

  // R10
  trip_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> tripped);
endmodule

// File: rtl/pwm3_phase.sv
module pwm3_phase
  import pwm3_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t cnt,
  input  word_t duty,
  input  word_t period,
  input  word_t minw,
  input  word_t dead,
  output logic  hi_on,
  output logic  lo_on
);
  wide_t thr;
  logic  raw;
  logic  raw_q;
  logic  raw_chg;
  word_t dcnt;
  logic  dead_idle;

  assign thr       = eff_duty(duty, period, minw);
  assign raw       = ({1'b0, cnt} < thr);
  assign raw_chg   = (raw != raw_q);
  assign dead_idle = (dcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
      dcnt  <= '0;
    end else if (raw_chg) begin
      raw_q <= raw;
      dcnt  <= dead;
    end else if (!dead_idle) begin
      dcnt  <= dcnt - word_t'(1);
    end
  end

  assign hi_on = raw_q  && dead_idle;
  assign lo_on = !raw_q && dead_idle;

  // R6
  dead_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_chg && (dead != '0)) |=> (!hi_on && !lo_on));

  // R3
  pair_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_on && lo_on));
endmodule

// File: rtl/pwm3_gen.sv
module pwm3_gen
  import pwm3_pkg::*;
#(
  parameter int PERIOD_RST = 100,
  parameter int CHOP_HALF  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic        trip,
  input  logic        pol_hi,
  output logic [2:0]  gate_hi,
  output logic [2:0]  gate_lo,
  output logic        sync
);
  localparam int NPH = 3;
  localparam int CHW = (CHOP_HALF > 1) ? $clog2(CHOP_HALF) : 1;

  word_t              cnt;
  logic               start_ev;
  logic               mid_ev;
  word_t              period_act;
  word_t [NPH-1:0]    duty_act;
  word_t              dead;
  word_t              minw;
  logic [CTRL_W-1:0]  ctrl;
  logic               tripped;
  logic [NPH-1:0]     hi_on;
  logic [NPH-1:0]     lo_on;
  logic [NPH-1:0]     act_hi;
  logic [NPH-1:0]     act_lo;
  logic               shut;
  logic               chop_q;
  logic [CHW-1:0]     chop_cnt;
  logic               gate_h_chop;
  logic               gate_l_chop;

  pwm3_regs #(.PERIOD_RST(PERIOD_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start_ev(start_ev), .mid_ev(mid_ev), .trip(trip),
    .period_act(period_act), .duty_act(duty_act), .dead(dead), .minw(minw),
    .ctrl(ctrl), .tripped(tripped)
  );

  pwm3_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .period(period_act),
    .cnt(cnt), .start_ev(start_ev), .mid_ev(mid_ev)
  );

  // Chopping carrier
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chop_cnt <= '0;
      chop_q   <= 1'b0;
    end else if (chop_cnt == CHW'(CHOP_HALF - 1)) begin
      chop_cnt <= '0;
      chop_q   <= ~chop_q;
    end else begin
      chop_cnt <= chop_cnt + CHW'(1);
    end
  end

  assign gate_h_chop = !ctrl[B_CHOPHI] || chop_q;
  assign gate_l_chop = !ctrl[B_CHOPLO] || chop_q;
  assign shut        = trip || tripped;
  assign sync        = start_ev;

  for (genvar i = 0; i < NPH; i++) begin : g_ph
    pwm3_phase u_ph (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .duty(duty_act[i]),
      .period(period_act), .minw(minw), .dead(dead),
      .hi_on(hi_on[i]), .lo_on(lo_on[i])
    );
    assign act_hi[i]  = hi_on[i] && ctrl[2*i]   && gate_h_chop && !shut;
    assign act_lo[i]  = lo_on[i] && ctrl[2*i+1] && gate_l_chop && !shut;
    assign gate_hi[i] = pol_hi ? act_hi[i] : !act_hi[i];
    assign gate_lo[i] = pol_hi ? act_lo[i] : !act_lo[i];
  end

  // R10
  trip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tripped |-> ((gate_hi == {NPH{!pol_hi}}) && (gate_lo == {NPH{!pol_hi}})));

  // R8
  chop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[B_CHOPHI] && !chop_q) |-> (gate_hi == {NPH{!pol_hi}}));
endmodule

// File: tb/pwm3_gen_bench.sv
module pwm3_gen_bench;
  localparam int PR = 8;
  localparam int CH = 3;
  localparam int WD_CYC = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        trip = 1'b0;
  logic        pol_hi = 1'b1;
  logic [2:0]  gate_hi;
  logic [2:0]  gate_lo;
  logic        sync;

  pwm3_gen #(.PERIOD_RST(PR), .CHOP_HALF(CH)) u_pwm3_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .trip(trip), .pol_hi(pol_hi), .gate_hi(gate_hi), .gate_lo(gate_lo), .sync(sync)
  );

  always #10 clk = ~clk;

  int    compared = 0;
  int    mismatched = 0;
  string cur_req = "R11";
  bit    done = 0;

  // reference model state
  int m_cnt, m_up, m_P, s_P, m_dt, m_mw, m_ctrl, m_chc, m_chop, m_trp;
  int m_duty[3];
  int s_duty[3];
  int m_rawq[3];
  int m_dc[3];

  function automatic int ref_thr(int d, int p, int mw);
    int on_t, off_t;
    on_t  = d;
    off_t = p - d;
    if (on_t < mw) return 0;
    if (off_t <= 0 || off_t < mw) return p + 1;
    return on_t;
  endfunction

  function automatic int bit_of(int v, int b);
    return (v >> b) & 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_up = 1; m_P = PR; s_P = PR; m_dt = 0; m_mw = 0; m_ctrl = 0;
      m_chc = 0; m_chop = 0; m_trp = 0;
      for (int i = 0; i < 3; i++) begin
        m_duty[i] = 0; s_duty[i] = 0; m_rawq[i] = 0; m_dc[i] = 0;
      end
    end else begin
      int nc, nu, r;
      bit at_start, at_mid;
      for (int i = 0; i < 3; i++) begin
        r = (m_cnt < ref_thr(m_duty[i], m_P, m_mw)) ? 1 : 0;
        if (r != m_rawq[i]) begin m_rawq[i] = r; m_dc[i] = m_dt; end
        else if (m_dc[i] > 0) m_dc[i] = m_dc[i] - 1;
      end
      at_start = (m_cnt == 0);
      at_mid   = (m_cnt == m_P);
      nu = m_up;
      if (m_cnt == 0) begin nu = 1; nc = 1; end
      else if (m_up == 1 && m_cnt >= m_P) begin nu = 0; nc = m_cnt - 1; end
      else if (m_up == 1) nc = m_cnt + 1;
      else nc = m_cnt - 1;
      m_cnt = nc; m_up = nu;
      if (at_start) begin
        m_P = (s_P == 0) ? 1 : s_P;
        for (int i = 0; i < 3; i++) m_duty[i] = s_duty[i];
      end else if (at_mid && bit_of(m_ctrl, 6) == 1) begin
        for (int i = 0; i < 3; i++) m_duty[i] = s_duty[i];
      end
      if (m_chc == CH - 1) begin m_chc = 0; m_chop = 1 - m_chop; end
      else m_chc = m_chc + 1;
      if (trip) m_trp = 1;
      else if (wr_en && wr_addr == 3'd7) m_trp = 0;
      if (wr_en) begin
        case (wr_addr)
          3'd0: s_P = wr_data;
          3'd1: s_duty[0] = wr_data;
          3'd2: s_duty[1] = wr_data;
          3'd3: s_duty[2] = wr_data;
          3'd4: m_dt = wr_data;
          3'd5: m_mw = wr_data;
          3'd6: m_ctrl = wr_data & 16'h1FF;
          default: ;
        endcase
      end
    end
  end

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int eh, el, hv, lv, live;
      eh = 0; el = 0;
      live = (!trip && m_trp == 0) ? 1 : 0;
      for (int i = 0; i < 3; i++) begin
        hv = (m_rawq[i] == 1 && m_dc[i] == 0 && bit_of(m_ctrl, 2*i) == 1 &&
              (bit_of(m_ctrl, 7) == 0 || m_chop == 1) && live == 1) ? 1 : 0;
        lv = (m_rawq[i] == 0 && m_dc[i] == 0 && bit_of(m_ctrl, 2*i+1) == 1 &&
              (bit_of(m_ctrl, 8) == 0 || m_chop == 1) && live == 1) ? 1 : 0;
        if (!pol_hi) begin hv = 1 - hv; lv = 1 - lv; end
        eh = eh | (hv << i);
        el = el | (lv << i);
      end
      check(cur_req, {26'd0, gate_hi, gate_lo}, (eh << 3) | el);
      check("R2", sync, (m_cnt == 0) ? 1 : 0);
    end
  end

  task automatic wr(int a, int d);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d[15:0];
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    #(20 * WD_CYC);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R11: reset state seen at the ports
    idle(3);
    @(negedge clk);
    check("R11", {29'd0, gate_hi}, 0);
    check("R11", {29'd0, gate_lo}, 0);
    check("R11", sync, 1);
    @(posedge clk); #2; rst_n = 1'b1;

    cur_req = "R1";
    idle(40);
    wr(0, 10); wr(6, 16'h3F);
    cur_req = "R3";
    wr(1, 3); wr(2, 5); wr(3, 8);
    idle(60);
    for (int k = 0; k < 12; k++) begin wr(1 + k % 3, (k * 4) % 13); idle(3 + k); end
    idle(40);

    cur_req = "R4";
    wr(5, 3); wr(1, 2); wr(2, 8); wr(3, 12);
    idle(60);
    wr(1, 3); wr(2, 7); wr(3, 0);
    idle(60);
    wr(5, 0);

    cur_req = "R5";
    wr(6, 16'h7F);
    for (int k = 0; k < 16; k++) begin wr(1 + k % 3, (k * 7) % 11); idle(2 + k % 5); end
    idle(40);
    wr(6, 16'h3F);
    for (int k = 0; k < 10; k++) begin wr(1 + k % 3, (k * 5) % 11); idle(4); end

    cur_req = "R6";
    wr(4, 2); idle(80);
    wr(4, 5); wr(1, 2); idle(80);
    wr(4, 1); idle(40);

    cur_req = "R7";
    wr(6, 16'h15); idle(50);
    wr(6, 16'h2A); idle(50);
    wr(6, 16'h09); idle(50);

    cur_req = "R8";
    wr(6, 16'hBF); idle(60);
    wr(6, 16'h13F); idle(60);
    wr(6, 16'h1FF); idle(60);
    wr(6, 16'h3F);

    cur_req = "R9";
    pol_hi = 1'b0; idle(60);

    cur_req = "R10";
    trip = 1'b1; idle(3);
    wr(7, 0); idle(3);
    trip = 1'b0; idle(20);
    wr(7, 0); idle(40);
    pol_hi = 1'b1;
    trip = 1'b1; @(posedge clk); #2; trip = 1'b0; idle(20);
    wr(7, 0); idle(30);

    cur_req = "R1";
    wr(4, 0); wr(0, 6); idle(50);
    wr(0, 0); idle(30);
    wr(0, 1); idle(20);
    wr(0, 3); wr(1, 1); wr(2, 2); wr(3, 4); idle(40);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule